// File: doc/BRIEF.md
# Additive Latency Command Posting Delay

This block sits behind the command decoder of a DRAM device model. A controller may send a read or a write straight after an activate. The command is posted: it is held for an additive latency, and only then does it reach the column logic. The latency comes from a 2-bit setting relative to the CAS latency. It is either zero, CL minus one or CL minus two. The block also tells the data path when data is due. Read data is due after the posting delay plus CL. Write data is due after the posting delay plus CWL.

Every accepted command moves down a shift line, one stage per clock. Each stage carries the command type, the auto-precharge flag and the address fields, so commands that overlap in flight never collide. A separate single-bit line for reads and another for writes produce the data-due strobes.

The latency settings are captured only while every line is empty. After that they stay frozen until the last command in flight has drained.

Top module: `al_post_delay`

## Requirements
- R1: The posting delay AL is decoded from `al_code_i` (the pair of mode bits 4 and 3, bit 4 in `al_code_i[1]`). Code 2'b00 gives AL=0, 2'b01 gives AL=CL-1, and 2'b10 gives AL=CL-2. The result never goes below zero.
- R2: Code 2'b11 drives `al_err_o` high, and the block then uses AL=0. `al_err_o` is low for every other code.
- R3: `int_valid_o` pulses for one cycle exactly AL cycles after the cycle in which `cmd_valid_i` was accepted. When AL=0 it pulses in the same cycle.
- R4: The command type, address and bank come out on `int_type_o`, `int_addr_o` and `int_bank_o` unchanged, together with their delayed valid. The type encoding is 2'b00 read, 2'b01 read with auto-precharge, 2'b10 write and 2'b11 write with auto-precharge. Bit 1 marks a write and bit 0 marks auto-precharge.
- R5: For a read, with or without auto-precharge, `rd_due_o` pulses once, AL+CL cycles after the command is accepted.
- R6: For a write, with or without auto-precharge, `wr_due_o` pulses once, AL+CWL cycles after the command is accepted.
- R7: A command can be accepted on every cycle, including the cycle after an activate, with no gap. Commands that overlap in flight all come out, in issue order, each with its own timing.
- R8: AL, CL and CWL are captured while the block is idle. Any change to them while commands are in flight is ignored, both by those commands and by commands issued before the block drains.
- R9: Reset discards every command in flight. After reset, no output pulses until a new command is accepted.
- R10: A CL above `MAX_CL` (default 14) is treated as `MAX_CL`. A CWL above `MAX_CWL` (default 10) is treated as `MAX_CWL`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid_i | input | 1 | External read or write command present |
| cmd_type_i | input | 2 | Command type (bit 1 write, bit 0 auto-precharge) |
| cmd_addr_i | input | ADDR_W (14) | Column address field |
| cmd_bank_i | input | BANK_W (3) | Bank field |
| al_code_i | input | 2 | Additive latency code (mode bits 4,3) |
| cl_i | input | CL_W (4) | CAS latency in cycles |
| cwl_i | input | CL_W (4) | CAS write latency in cycles |
| int_valid_o | output | 1 | Posted command released internally |
| int_type_o | output | 2 | Type of the released command |
| int_addr_o | output | ADDR_W (14) | Address of the released command |
| int_bank_o | output | BANK_W (3) | Bank of the released command |
| rd_due_o | output | 1 | Read data due (AL+CL after the read) |
| wr_due_o | output | 1 | Write data due (AL+CWL after the write) |
| al_err_o | output | 1 | Reserved additive latency code in use |

## Verification
Take the cycle in which a command is presented as offset 0. The internal command is due at offset AL, read data at offset AL+CL and write data at offset AL+CWL. At AL=0 the internal command appears at offset 0, with no register on the way. For every scenario the bench records all outputs at each offset over a 40-cycle window, sampling one nanosecond after the falling edge. It then compares this record with a timeline it builds from its own latency arithmetic, using the settings present at offset 0. The window is longer than the deepest read latency, so a pulse that is early, late, doubled or missing shows up as a mismatch at a named offset.

// File: rtl/al_pkg.sv
package al_pkg;
  // width of every latency value inside the block
  localparam int LAT_W = 6;
  // command type bit positions
  localparam int CMD_WR_BIT = 1;
  localparam int CMD_AP_BIT = 0;

  typedef logic [LAT_W-1:0] lat_t;

  // limit a latency setting to the deepest supported value
  function automatic lat_t lat_clamp(input lat_t v, input lat_t lim);
    return (v > lim) ? lim : v;
  endfunction

  // additive latency from the 2-bit code; reserved code yields zero
  function automatic lat_t al_decode(input logic [1:0] code, input lat_t cl);
    lat_t r;
    unique case (code)
      2'b01:   r = (cl >= lat_t'(1)) ? cl - lat_t'(1) : '0;
      2'b10:   r = (cl >= lat_t'(2)) ? cl - lat_t'(2) : '0;
      default: r = '0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/al_cfg_hold.sv
module al_cfg_hold
  import al_pkg::*;
#(
  parameter int CL_W    = 4,
  parameter int MAX_CL  = 14,
  parameter int MAX_CWL = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            busy_i,
  input  logic [1:0]      code_i,
  input  logic [CL_W-1:0] cl_i,
  input  logic [CL_W-1:0] cwl_i,
  output lat_t            al_o,
  output lat_t            rl_o,
  output lat_t            wl_o,
  output logic            err_o
);
  logic [1:0]      code_q, code_eff;
  logic [CL_W-1:0] cl_q, cl_eff, cwl_q, cwl_eff;
  lat_t            cl_lim, cwl_lim;

  // live settings while idle, frozen copy while anything is in flight
  assign code_eff = busy_i ? code_q : code_i;
  assign cl_eff   = busy_i ? cl_q   : cl_i;
  assign cwl_eff  = busy_i ? cwl_q  : cwl_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_q <= '0;
      cl_q   <= '0;
      cwl_q  <= '0;
    end else begin
      code_q <= code_eff;
      cl_q   <= cl_eff;
      cwl_q  <= cwl_eff;
    end
  end

  assign cl_lim  = lat_clamp(lat_t'(cl_eff),  lat_t'(MAX_CL));
  assign cwl_lim = lat_clamp(lat_t'(cwl_eff), lat_t'(MAX_CWL));
  assign err_o   = (code_eff == 2'b11);
  assign al_o    = al_decode(code_eff, cl_lim);
  assign rl_o    = al_o + cl_lim;
  assign wl_o    = al_o + cwl_lim;

  // R2
  err_al_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (al_o == '0));

  // R8
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |-> ($stable(al_o) && $stable(rl_o) && $stable(wl_o)));
endmodule

// File: rtl/al_cmd_line.sv
module al_cmd_line
  import al_pkg::*;
#(
  parameter int DEPTH = 13,
  parameter int PW    = 19
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [PW-1:0] in_pl,
  input  lat_t          tap,
  output logic          out_valid,
  output logic [PW-1:0] out_pl,
  output logic          busy_o
);
  logic          vld [DEPTH+1];
  logic [PW-1:0] pl  [DEPTH+1];

  assign vld[0] = in_valid;
  assign pl[0]  = in_pl;

  for (genvar k = 1; k <= DEPTH; k++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld[k] <= 1'b0;
        pl[k]  <= '0;
      end else begin
        vld[k] <= vld[k-1];
        pl[k]  <= pl[k-1];
      end
    end
  end

  always_comb begin
    out_valid = 1'b0;
    out_pl    = '0;
    busy_o    = 1'b0;
    for (int i = 0; i <= DEPTH; i++) begin
      if (tap == lat_t'(i) && vld[i]) begin
        out_valid = 1'b1;
        out_pl    = pl[i];
      end
      if (i > 0) busy_o = busy_o | vld[i];
    end
  end
endmodule

// File: rtl/al_pulse_line.sv
module al_pulse_line
  import al_pkg::*;
#(
  parameter int DEPTH = 27
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_pulse,
  input  lat_t tap,
  output logic out_pulse,
  output logic busy_o
);
  logic [DEPTH:0] sr;

  assign sr[0] = in_pulse;

  for (genvar k = 1; k <= DEPTH; k++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) sr[k] <= 1'b0;
      else        sr[k] <= sr[k-1];
    end
  end

  always_comb begin
    out_pulse = 1'b0;
    for (int i = 0; i <= DEPTH; i++)
      if (tap == lat_t'(i)) out_pulse = sr[i];
  end

  assign busy_o = |sr[DEPTH:1];
endmodule

// File: rtl/al_post_delay.sv
module al_post_delay
  import al_pkg::*;
#(
  parameter int CL_W    = 4,
  parameter int ADDR_W  = 14,
  parameter int BANK_W  = 3,
  parameter int MAX_CL  = 14,
  parameter int MAX_CWL = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid_i,
  input  logic [1:0]        cmd_type_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [BANK_W-1:0] cmd_bank_i,
  input  logic [1:0]        al_code_i,
  input  logic [CL_W-1:0]   cl_i,
  input  logic [CL_W-1:0]   cwl_i,
  output logic              int_valid_o,
  output logic [1:0]        int_type_o,
  output logic [ADDR_W-1:0] int_addr_o,
  output logic [BANK_W-1:0] int_bank_o,
  output logic              rd_due_o,
  output logic              wr_due_o,
  output logic              al_err_o
);
  localparam int MAX_AL = MAX_CL - 1;
  localparam int MAX_RL = MAX_AL + MAX_CL;
  localparam int MAX_WL = MAX_AL + MAX_CWL;
  localparam int PW     = 2 + BANK_W + ADDR_W;
  localparam int IW     = $clog2(MAX_RL + 2) + 1;

  lat_t          al, rl, wl;
  logic          busy, cmd_busy, rd_busy, wr_busy;
  logic          rd_in, wr_in;
  logic [PW-1:0] pl_out;

  assign rd_in = cmd_valid_i & ~cmd_type_i[CMD_WR_BIT];
  assign wr_in = cmd_valid_i &  cmd_type_i[CMD_WR_BIT];
  assign busy  = cmd_busy | rd_busy | wr_busy;

  al_cfg_hold #(.CL_W(CL_W), .MAX_CL(MAX_CL), .MAX_CWL(MAX_CWL)) u_cfg (
    .clk(clk), .rst_n(rst_n), .busy_i(busy),
    .code_i(al_code_i), .cl_i(cl_i), .cwl_i(cwl_i),
    .al_o(al), .rl_o(rl), .wl_o(wl), .err_o(al_err_o)
  );

  al_cmd_line #(.DEPTH(MAX_AL), .PW(PW)) u_cmd (
    .clk(clk), .rst_n(rst_n),
    .in_valid(cmd_valid_i), .in_pl({cmd_type_i, cmd_bank_i, cmd_addr_i}),
    .tap(al), .out_valid(int_valid_o), .out_pl(pl_out), .busy_o(cmd_busy)
  );

  assign {int_type_o, int_bank_o, int_addr_o} = pl_out;

  al_pulse_line #(.DEPTH(MAX_RL)) u_rd (
    .clk(clk), .rst_n(rst_n), .in_pulse(rd_in), .tap(rl),
    .out_pulse(rd_due_o), .busy_o(rd_busy)
  );

  al_pulse_line #(.DEPTH(MAX_WL)) u_wr (
    .clk(clk), .rst_n(rst_n), .in_pulse(wr_in), .tap(wl),
    .out_pulse(wr_due_o), .busy_o(wr_busy)
  );

  // in-flight tallies, kept only for the properties below
  logic [IW-1:0] cmd_cnt_q, rd_cnt_q, wr_cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_cnt_q <= '0;
      rd_cnt_q  <= '0;
      wr_cnt_q  <= '0;
    end else begin
      cmd_cnt_q <= cmd_cnt_q + IW'(cmd_valid_i) - IW'(int_valid_o);
      rd_cnt_q  <= rd_cnt_q  + IW'(rd_in) - IW'(rd_due_o);
      wr_cnt_q  <= wr_cnt_q  + IW'(wr_in) - IW'(wr_due_o);
    end
  end

  // R3
  zero_al_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (al == '0) |-> (int_valid_o == cmd_valid_i));

  // R7
  no_cmd_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_valid_o |-> (cmd_cnt_q != '0 || cmd_valid_i));

  // R5
  rd_due_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_due_o |-> (rd_cnt_q != '0 || rd_in));

  // R6
  wr_due_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_due_o |-> (wr_cnt_q != '0 || wr_in));

  // R9
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!rd_due_o && !wr_due_o && (int_valid_o == cmd_valid_i || al != '0)));
endmodule

// File: tb/test_al_post_delay.sv
`timescale 1ns/1ps
module test_al_post_delay;
  localparam int WIN = 40;
  localparam int NV  = 8;
  // {code[2], cl[4], cwl[4], type[2], addr[14], bank[3]}
  localparam logic [28:0] VEC [NV] = '{
    {2'd0, 4'd6,  4'd5,  2'b00, 14'h0123, 3'd1},
    {2'd1, 4'd6,  4'd5,  2'b10, 14'h1ABC, 3'd2},
    {2'd2, 4'd9,  4'd7,  2'b01, 14'h3FFF, 3'd7},
    {2'd2, 4'd9,  4'd7,  2'b11, 14'h0001, 3'd0},
    {2'd3, 4'd8,  4'd6,  2'b00, 14'h2222, 3'd3},
    {2'd1, 4'd11, 4'd8,  2'b11, 14'h0F0F, 3'd5},
    {2'd1, 4'd15, 4'd15, 2'b00, 14'h1555, 3'd6},
    {2'd2, 4'd15, 4'd15, 2'b10, 14'h2AAA, 3'd4}
  };

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cmd_valid_i = 1'b0;
  logic [1:0]  cmd_type_i = '0, al_code_i = '0;
  logic [13:0] cmd_addr_i = '0;
  logic [2:0]  cmd_bank_i = '0;
  logic [3:0]  cl_i = 4'd6, cwl_i = 4'd5;
  logic        int_valid_o, rd_due_o, wr_due_o, al_err_o;
  logic [1:0]  int_type_o;
  logic [13:0] int_addr_o;
  logic [2:0]  int_bank_o;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  al_post_delay i_al_post_delay (
    .clk(clk), .rst_n(rst_n), .cmd_valid_i(cmd_valid_i), .cmd_type_i(cmd_type_i),
    .cmd_addr_i(cmd_addr_i), .cmd_bank_i(cmd_bank_i), .al_code_i(al_code_i),
    .cl_i(cl_i), .cwl_i(cwl_i), .int_valid_o(int_valid_o), .int_type_o(int_type_o),
    .int_addr_o(int_addr_o), .int_bank_o(int_bank_o), .rd_due_o(rd_due_o),
    .wr_due_o(wr_due_o), .al_err_o(al_err_o)
  );

  // scenario description: up to 4 commands on consecutive cycles
  int          sc_n;
  logic [1:0]  sc_code [4];
  logic [3:0]  sc_cl [4], sc_cwl [4];
  logic [1:0]  sc_type [4];
  logic [13:0] sc_addr [4];
  logic [2:0]  sc_bank [4];

  logic        cap_iv [WIN], cap_rd [WIN], cap_wr [WIN];
  logic [18:0] cap_f [WIN];
  logic        cap_err0;

  function automatic int m_cl(input logic [3:0] v);
    return (int'(v) > 14) ? 14 : int'(v);
  endfunction
  function automatic int m_cwl(input logic [3:0] v);
    return (int'(v) > 10) ? 10 : int'(v);
  endfunction
  function automatic int m_al(input logic [1:0] code, input logic [3:0] cl);
    int c = m_cl(cl);
    if (code == 2'd1) return c - 1;
    if (code == 2'd2) return c - 2;
    return 0;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic run_sc(input string tag);
    logic        e_iv [WIN], e_rd [WIN], e_wr [WIN];
    logic [18:0] e_f [WIN];
    int al, rl, wl, bad_iv, bad_f, bad_rd, bad_wr;
    @(negedge clk);
    for (int k = 0; k < WIN; k++) begin
      if (k < sc_n) begin
        cmd_valid_i = 1'b1;
        cmd_type_i  = sc_type[k];
        cmd_addr_i  = sc_addr[k];
        cmd_bank_i  = sc_bank[k];
        al_code_i   = sc_code[k];
        cl_i        = sc_cl[k];
        cwl_i       = sc_cwl[k];
      end else begin
        cmd_valid_i = 1'b0;
      end
      #1;
      cap_iv[k] = int_valid_o;
      cap_rd[k] = rd_due_o;
      cap_wr[k] = wr_due_o;
      cap_f[k]  = {int_type_o, int_bank_o, int_addr_o};
      if (k == 0) cap_err0 = al_err_o;
      @(negedge clk);
    end
    // expected timeline, all commands on the settings seen at offset 0
    al = m_al(sc_code[0], sc_cl[0]);
    rl = al + m_cl(sc_cl[0]);
    wl = al + m_cwl(sc_cwl[0]);
    for (int k = 0; k < WIN; k++) begin
      e_iv[k] = 0; e_rd[k] = 0; e_wr[k] = 0; e_f[k] = '0;
    end
    for (int j = 0; j < sc_n; j++) begin
      e_iv[j+al] = 1;
      e_f[j+al]  = {sc_type[j], sc_bank[j], sc_addr[j]};
      if (sc_type[j][1]) e_wr[j+wl] = 1;
      else               e_rd[j+rl] = 1;
    end
    bad_iv = -1; bad_f = -1; bad_rd = -1; bad_wr = -1;
    for (int k = WIN-1; k >= 0; k--) begin
      if (cap_iv[k] !== e_iv[k]) bad_iv = k;
      if (e_iv[k] && cap_f[k] !== e_f[k]) bad_f = k;
      if (cap_rd[k] !== e_rd[k]) bad_rd = k;
      if (cap_wr[k] !== e_wr[k]) bad_wr = k;
    end
    chk(bad_iv < 0, {"R3 ", tag}, "int_valid at offset",
        bad_iv < 0 ? 0 : int'(cap_iv[bad_iv]), bad_iv < 0 ? 0 : int'(e_iv[bad_iv]));
    chk(bad_f < 0, {"R4 ", tag}, "fields at offset",
        bad_f < 0 ? 0 : int'(cap_f[bad_f]), bad_f < 0 ? 0 : int'(e_f[bad_f]));
    chk(bad_rd < 0, {"R5 ", tag}, "rd_due at offset",
        bad_rd < 0 ? 0 : int'(cap_rd[bad_rd]), bad_rd < 0 ? 0 : int'(e_rd[bad_rd]));
    chk(bad_wr < 0, {"R6 ", tag}, "wr_due at offset",
        bad_wr < 0 ? 0 : int'(cap_wr[bad_wr]), bad_wr < 0 ? 0 : int'(e_wr[bad_wr]));
    chk(cap_err0 === (sc_code[0] == 2'd3), {"R2 ", tag}, "al_err_o",
        int'(cap_err0), int'(sc_code[0] == 2'd3));
  endtask

  task automatic set_cmd(input int j, input logic [1:0] code, input logic [3:0] cl,
                         input logic [3:0] cwl, input logic [1:0] ty,
                         input logic [13:0] ad, input logic [2:0] bk);
    sc_code[j] = code; sc_cl[j] = cl; sc_cwl[j] = cwl;
    sc_type[j] = ty;   sc_addr[j] = ad; sc_bank[j] = bk;
  endtask

  task automatic report;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #800000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      report();
      $finish;
    end
  end

  initial begin
    // R9: quiet during and right after reset
    repeat (4) @(negedge clk);
    #1;
    chk(!int_valid_o && !rd_due_o && !wr_due_o, "R9", "outputs in reset",
        int'({int_valid_o, rd_due_o, wr_due_o}), 0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(!int_valid_o && !rd_due_o && !wr_due_o, "R9", "outputs after reset",
        int'({int_valid_o, rd_due_o, wr_due_o}), 0);

    // table walk: R1, R2, R10 settings with single commands
    for (int v = 0; v < NV; v++) begin
      sc_n = 1;
      set_cmd(0, VEC[v][28:27], VEC[v][26:23], VEC[v][22:19],
              VEC[v][18:17], VEC[v][16:3], VEC[v][2:0]);
      run_sc((v >= 6) ? "R10 clamp vector" : "R1 table vector");
    end

    // R7: back-to-back commands of all four types
    sc_n = 4;
    set_cmd(0, 2'd1, 4'd6, 4'd5, 2'b00, 14'h0011, 3'd1);
    set_cmd(1, 2'd1, 4'd6, 4'd5, 2'b10, 14'h0022, 3'd2);
    set_cmd(2, 2'd1, 4'd6, 4'd5, 2'b01, 14'h0033, 3'd3);
    set_cmd(3, 2'd1, 4'd6, 4'd5, 2'b11, 14'h0044, 3'd4);
    run_sc("R7 back-to-back");

    // R7 at AL=0: overlapping reads and writes
    set_cmd(0, 2'd0, 4'd5, 4'd5, 2'b10, 14'h0100, 3'd0);
    set_cmd(1, 2'd0, 4'd5, 4'd5, 2'b00, 14'h0200, 3'd7);
    set_cmd(2, 2'd0, 4'd5, 4'd5, 2'b11, 14'h0300, 3'd6);
    set_cmd(3, 2'd0, 4'd5, 4'd5, 2'b01, 14'h0400, 3'd5);
    run_sc("R7 zero AL");

    // R8: settings changed while commands are in flight are ignored
    sc_n = 3;
    set_cmd(0, 2'd1, 4'd6, 4'd5, 2'b00, 14'h0A0A, 3'd1);
    set_cmd(1, 2'd0, 4'd9, 4'd8, 2'b10, 14'h0B0B, 3'd2);
    set_cmd(2, 2'd2, 4'd12, 4'd9, 2'b00, 14'h0C0C, 3'd3);
    run_sc("R8 frozen settings");

    // R8: after draining, new settings take effect
    sc_n = 1;
    set_cmd(0, 2'd2, 4'd12, 4'd9, 2'b10, 14'h0D0D, 3'd4);
    run_sc("R8 new settings after drain");

    // R9: reset discards a command in flight
    @(negedge clk);
    al_code_i = 2'd1; cl_i = 4'd9; cwl_i = 4'd5;
    cmd_type_i = 2'b10; cmd_addr_i = 14'h1234; cmd_valid_i = 1'b1;
    @(negedge clk); cmd_valid_i = 1'b0;
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    begin
      int seen = 0;
      for (int k = 0; k < WIN; k++) begin
        #1;
        if (int_valid_o || rd_due_o || wr_due_o) seen++;
        @(negedge clk);
      end
      chk(seen == 0, "R9", "pulses after mid-flight reset", seen, 0);
    end

    done = 1;
    report();
    $finish;
  end
endmodule